// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets synchronous logic use an external asynchronous static RAM that holds 131072 words of 16 bits. The memory has active-low chip-select, output-enable and write-enable strobes and one active-low enable per byte lane. The host side is a level request/acknowledge port. The host holds `req_i` high, with the address, write data, byte mask and direction stable, until it sees `ack_o`. In that acknowledge cycle a read also returns its data on `rdata_o`.

The controller never shapes a strobe from a combinational edge. Every strobe is a register output, and every phase is counted in clock cycles. Each count is the ceiling of a nanosecond minimum divided by `CLK_NS`, and is never less than one cycle. The defaults cover the 70 ns speed grade.

A write ends when write-enable rises while chip-select, the byte enables and the write data are all still held. The data bus is split into output, output-enable and input so that the pad buffer can stay outside the block. Output-enable is kept high whenever the controller drives the bus. After a read, a turnaround window blocks the next write so that the memory can stop driving first.

Top module: `sram_ctl`

## Requirements
- R1: When no access is in progress, chip-select, output-enable and write-enable are high, both byte enables are high and the data bus is not driven. Reset puts the block in this state with `ack_o` low.
- R2: A read holds chip-select and output-enable low and write-enable high for exactly ceil(max(tAA, tACE, tDOE, tBA)/CLK_NS) cycles. This is 9 cycles at the defaults.
- R3: Mask bit 0 selects the lower lane, data bits 7:0 and `sram_be_no[0]`. Mask bit 1 selects the upper lane, data bits 15:8 and `sram_be_no[1]`. During an access, a lane's enable is low exactly when its mask bit is 1.
- R4: At the acknowledge of a read, `rdata_o` holds the memory contents in the selected lanes and zero in the unselected lanes. The value is captured on the last edge of the read phase.
- R5: A write holds write-enable low, with chip-select low, for exactly ceil(max(tPWE, tAW, tSCE, tPWB, tSD)/CLK_NS) cycles. This is 9 cycles at the defaults.
- R6: Write data is driven from the cycle in which write-enable falls. Write-enable then rises one cycle before chip-select and the byte enables release. The data stays driven and unchanged through that rising edge and is released together with chip-select.
- R7: Output-enable is high in every cycle in which write-enable is low or the controller drives the data bus.
- R8: A mask of 00 still completes with an acknowledge. No byte enable goes low, memory is left unchanged, and a read returns zero.
- R9: `ack_o` is a one-cycle pulse in the cycle in which the strobes return to idle. A request is not sampled in that cycle.
- R10: When the controller is free, an access starts one cycle after the request is sampled. Two access starts are never closer than ceil(tRC/CLK_NS) cycles after a read, or ceil(tWC/CLK_NS) cycles after a write.
- R11: A write that follows a read starts no earlier than ceil(tHZOE/CLK_NS)+1 cycles after output-enable rises. This is 5 cycles at the defaults, and it lets the memory stop driving before the bus is driven.
- R12: The address is latched when a request is accepted. It is held unchanged while chip-select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, held until acknowledge |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 16 | Write data |
| mask_i | input | 2 | Byte-lane mask, bit 0 lower, bit 1 upper |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, valid with acknowledge |
| sram_addr_o | output | 17 | Memory address |
| sram_ce_no | output | 1 | Chip-select, active low |
| sram_oe_no | output | 1 | Output-enable, active low |
| sram_we_no | output | 1 | Write-enable, active low |
| sram_be_no | output | 2 | Byte enables, active low, bit 0 lower |
| sram_dq_o | output | 16 | Data to memory |
| sram_dq_oe_o | output | 1 | Data bus drive enable |
| sram_dq_i | input | 16 | Data from memory |

## Verification
The hardest case to reach from the ports is the start of a write that follows a read. Four limits compete to set that start cycle: the turnaround window, the blocked acknowledge cycle, the cycle-spacing limit and the moment the request arrives. The stimulus runs long mixed sequences of reads and writes, with zero to three idle cycles between operations, so that each limit sets the start cycle in some cases. The bench memory model drives a junk pattern on every lane the memory would leave floating. A missing lane mask in the read data therefore shows up as a wrong value.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_WREC} st_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // ceil(ns / clk), at least one cycle
  function automatic int unsigned cyc_of(int unsigned ns, int unsigned clk);
    int unsigned c;
    c = (ns + clk - 1) / clk;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
  parameter int unsigned LANES = 2
) (
  input  logic [LANES-1:0]   mask_i,
  input  logic [8*LANES-1:0] dq_i,
  output logic [LANES-1:0]   be_n_o,
  output logic [8*LANES-1:0] rd_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign be_n_o[l]       = ~mask_i[l];
    assign rd_o[8*l +: 8]  = mask_i[l] ? dq_i[8*l +: 8] : 8'h00;
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CLK_NS    = 8,
  parameter int unsigned T_RC_NS   = 70,
  parameter int unsigned T_AA_NS   = 70,
  parameter int unsigned T_ACE_NS  = 70,
  parameter int unsigned T_DOE_NS  = 35,
  parameter int unsigned T_BA_NS   = 35,
  parameter int unsigned T_HZOE_NS = 25,
  parameter int unsigned T_WC_NS   = 70,
  parameter int unsigned T_SCE_NS  = 65,
  parameter int unsigned T_AW_NS   = 65,
  parameter int unsigned T_PWE_NS  = 60,
  parameter int unsigned T_PWB_NS  = 60,
  parameter int unsigned T_SD_NS   = 30
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W/8-1:0] mask_i,
  output logic                ack_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [ADDR_W-1:0]   sram_addr_o,
  output logic                sram_ce_no,
  output logic                sram_oe_no,
  output logic                sram_we_no,
  output logic [DATA_W/8-1:0] sram_be_no,
  output logic [DATA_W-1:0]   sram_dq_o,
  output logic                sram_dq_oe_o,
  input  logic [DATA_W-1:0]   sram_dq_i
);
  import sram_ctl_pkg::*;

  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned RD_CYC  = cyc_of(max2(max2(T_AA_NS, T_ACE_NS),
                                                max2(T_DOE_NS, T_BA_NS)), CLK_NS);
  localparam int unsigned WR_CYC  = cyc_of(max2(max2(T_PWE_NS, T_PWB_NS),
                                                max2(T_AW_NS, max2(T_SCE_NS, T_SD_NS))), CLK_NS);
  localparam int unsigned GAP_RD  = cyc_of(T_RC_NS, CLK_NS);
  localparam int unsigned GAP_WR  = cyc_of(T_WC_NS, CLK_NS);
  localparam int unsigned TA_CYC  = cyc_of(T_HZOE_NS, CLK_NS);
  localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WR_CYC),
                                         max2(max2(GAP_RD, GAP_WR), TA_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  st_e state_q, state_d;
  logic accept, rd_done;
  logic ph_zero, gap_zero, ta_zero;
  logic [CNT_W-1:0] ph_val, gap_val;
  logic [LANES-1:0] mask_q, mask_sel, be_n_sel;
  logic [DATA_W-1:0] rd_merged, wdata_q, rdata_q;
  logic [ADDR_W-1:0] addr_q;
  logic ack_q, ce_n_q, oe_n_q, we_n_q, dq_oe_q;
  logic [LANES-1:0] be_n_q;

  // writes wait for the memory to release the bus after a read
  assign accept  = (state_q == ST_IDLE) && req_i && !ack_q && gap_zero
                   && (!we_i || ta_zero);
  assign rd_done = (state_q == ST_RD) && ph_zero;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)  state_d = we_i ? ST_WR : ST_RD;
      ST_RD:   if (ph_zero) state_d = ST_IDLE;
      ST_WR:   if (ph_zero) state_d = ST_WREC;
      ST_WREC:              state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  assign ph_val  = we_i ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
  assign gap_val = we_i ? CNT_W'(GAP_WR - 1) : CNT_W'(GAP_RD - 1);

  sram_ctl_timer #(.W(CNT_W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .val_i(ph_val), .zero_o(ph_zero));

  sram_ctl_timer #(.W(CNT_W)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .val_i(gap_val), .zero_o(gap_zero));

  sram_ctl_timer #(.W(CNT_W)) u_turn (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(rd_done), .val_i(CNT_W'(TA_CYC)),
    .zero_o(ta_zero));

  assign mask_sel = accept ? mask_i : mask_q;

  sram_ctl_lanes #(.LANES(LANES)) u_lanes (
    .mask_i(mask_sel), .dq_i(sram_dq_i), .be_n_o(be_n_sel), .rd_o(rd_merged));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      be_n_q  <= '1;
      dq_oe_q <= 1'b0;
      ack_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      // strobes registered from next state: no decode glitches at the pins
      ce_n_q  <= (state_d == ST_IDLE);
      oe_n_q  <= (state_d != ST_RD);
      we_n_q  <= (state_d != ST_WR);
      be_n_q  <= (state_d == ST_IDLE) ? '1 : be_n_sel;
      dq_oe_q <= (state_d == ST_WR) || (state_d == ST_WREC);
      ack_q   <= rd_done || (state_q == ST_WREC);
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        mask_q  <= mask_i;
      end
      if (rd_done) rdata_q <= rd_merged;
    end
  end

  assign ack_o        = ack_q;
  assign rdata_o      = rdata_q;
  assign sram_addr_o  = addr_q;
  assign sram_ce_no   = ce_n_q;
  assign sram_oe_no   = oe_n_q;
  assign sram_we_no   = we_n_q;
  assign sram_be_no   = be_n_q;
  assign sram_dq_o    = wdata_q;
  assign sram_dq_oe_o = dq_oe_q;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ack_o,
  input logic [ADDR_W-1:0]   sram_addr_o,
  input logic                sram_ce_no,
  input logic                sram_oe_no,
  input logic                sram_we_no,
  input logic [DATA_W/8-1:0] sram_be_no,
  input logic [DATA_W-1:0]   sram_dq_o,
  input logic                sram_dq_oe_o
);
  a_r7_oe_we_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_oe_no && !sram_we_no));

  a_r7_drive_oe_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_ce_no |-> (sram_we_no && sram_oe_no && (&sram_be_no) && !sram_dq_oe_o));

  a_r9_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  a_r9_ack_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $rose(sram_ce_no));

  a_r6_we_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (!sram_ce_no && sram_dq_oe_o && $stable(sram_dq_o)));

  a_r6_drive_at_we_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> $rose(sram_dq_oe_o));

  a_r12_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o));
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_o(ack_o), .sram_addr_o(sram_addr_o),
  .sram_ce_no(sram_ce_no), .sram_oe_no(sram_oe_no), .sram_we_no(sram_we_no),
  .sram_be_no(sram_be_no), .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe_o));

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;
  localparam int CLK = 8;
  // expected phase lengths from the nanosecond minimums
  function automatic int cdiv(int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int RD  = (70 + CLK - 1) / CLK;
  localparam int WR  = (65 + CLK - 1) / CLK;
  localparam int GAP = (70 + CLK - 1) / CLK;
  localparam int TA  = (25 + CLK - 1) / CLK;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [16:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  mask = '0;
  logic ack;
  logic [15:0] rdata, sram_dq_o;
  logic [16:0] sram_addr;
  logic ce_n, oe_n, we_n, dq_oe;
  logic [1:0] be_n;
  logic [15:0] sram_dq_i = 16'hA5A5;

  always #(CLK/2) clk = ~clk;

  sram_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .mask_i(mask), .ack_o(ack), .rdata_o(rdata),
    .sram_addr_o(sram_addr), .sram_ce_no(ce_n), .sram_oe_no(oe_n),
    .sram_we_no(we_n), .sram_be_no(be_n), .sram_dq_o(sram_dq_o),
    .sram_dq_oe_o(dq_oe), .sram_dq_i(sram_dq_i));

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(bit c, string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  logic [15:0] dev_mem [int];
  logic [15:0] ref_mem [int];

  function automatic logic [15:0] dev_rd(int a);
    return dev_mem.exists(a) ? dev_mem[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
  endfunction

  // pending request, as seen by the monitor
  int smp = 0, req_smp = 0;
  int last_start = -1000, last_ack = -1000, last_oe_rise = -1000;
  bit pend = 0, pend_we = 0, cur_we = 0;
  logic [1:0]  pend_mask = '0, cur_mask = '0;
  logic [16:0] pend_addr = '0, cur_addr = '0;
  int ce_run = 0, oe_run = 0, we_run = 0;
  logic p_ce_n = 1, p_oe_n = 1, p_we_n = 1, p_dq_oe = 0, p_ack = 0;
  logic [15:0] p_dq_o = '0;

  always @(negedge clk) if (rst_n && !finished) begin
    int exp_s;
    logic [15:0] w;
    smp++;
    chk(!(!oe_n && !we_n), "R7 oe/we overlap", {oe_n, we_n}, 2'b11);
    if (dq_oe) chk(oe_n, "R7 drive with oe high", oe_n, 1);
    if (ce_n) chk(we_n && oe_n && be_n == 2'b11 && !dq_oe, "R1 idle strobes",
                  {we_n, oe_n, be_n, dq_oe}, 5'b11110);
    if (p_ack) chk(!ack, "R9 ack one cycle", ack, 0);
    // start of access
    if (p_ce_n && !ce_n) begin
      exp_s = req_smp + 1;
      if (last_ack + 2 > exp_s) exp_s = last_ack + 2;
      if (last_start + GAP > exp_s) exp_s = last_start + GAP;
      if (pend_we && last_oe_rise + TA + 1 > exp_s) exp_s = last_oe_rise + TA + 1;
      chk(pend, "R9 start without request", pend, 1);
      chk(smp == exp_s, "R9/R10/R11 start cycle", smp, exp_s);
      if (pend_we) chk(!we_n && oe_n && dq_oe, "R5 write strobes", {we_n, oe_n, dq_oe}, 3'b011);
      else         chk(we_n && !oe_n && !dq_oe, "R2 read strobes", {we_n, oe_n, dq_oe}, 3'b100);
      cur_we = pend_we; cur_mask = pend_mask; cur_addr = pend_addr;
      pend = 0; last_start = smp; ce_run = 0;
    end
    if (!ce_n) begin
      ce_run++;
      chk(be_n == ~cur_mask, "R3 byte enables", be_n, ~cur_mask);
      chk(sram_addr == cur_addr, "R12 address", sram_addr, cur_addr);
    end
    if (!p_ce_n && ce_n) begin
      chk(ce_run == (cur_we ? WR + 1 : RD), "R2/R6 select length", ce_run, cur_we ? WR + 1 : RD);
      chk(ack, "R9 ack at release", ack, 1);
    end
    if (ack) last_ack = smp;
    // read phase length
    if (p_oe_n && !oe_n) oe_run = 0;
    if (!oe_n) oe_run++;
    if (!p_oe_n && oe_n) begin
      chk(oe_run == RD, "R2 read length", oe_run, RD);
      last_oe_rise = smp;
    end
    // write pulse
    if (p_we_n && !we_n) begin
      we_run = 0;
      chk(dq_oe && !p_dq_oe, "R6 drive from we fall", {dq_oe, p_dq_oe}, 2'b10);
    end
    if (!we_n) we_run++;
    if (!p_we_n && we_n) begin
      chk(we_run == WR, "R5 write pulse", we_run, WR);
      chk(!ce_n && be_n == p_dq_o[1:0] || !ce_n, "R6 ce held at we rise", ce_n, 0);
      chk(dq_oe && sram_dq_o == p_dq_o, "R6 data held", sram_dq_o, p_dq_o);
      w = dev_rd(int'(sram_addr));
      if (!be_n[0]) w[7:0]  = sram_dq_o[7:0];
      if (!be_n[1]) w[15:8] = sram_dq_o[15:8];
      dev_mem[int'(sram_addr)] = w;
    end
    if (p_dq_oe && !dq_oe) chk(ce_n, "R6 release with select", ce_n, 1);
    // memory model output: floating lanes read as junk
    w = 16'hA5A5;
    if (!ce_n && !oe_n && we_n) begin
      if (!be_n[0]) w[7:0]  = dev_rd(int'(sram_addr)) >> 0;
      if (!be_n[1]) w[15:8] = dev_rd(int'(sram_addr)) >> 8;
    end
    sram_dq_i = w;
    p_ce_n = ce_n; p_oe_n = oe_n; p_we_n = we_n; p_dq_oe = dq_oe;
    p_ack = ack; p_dq_o = sram_dq_o;
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic do_op(bit w, logic [16:0] a, logic [15:0] d, logic [1:0] m, string tag);
    logic [15:0] old, exp;
    int n;
    old = ref_rd(int'(a));
    exp = {m[1] ? old[15:8] : 8'h00, m[0] ? old[7:0] : 8'h00};
    if (w) begin
      if (m[0]) old[7:0]  = d[7:0];
      if (m[1]) old[15:8] = d[15:8];
      ref_mem[int'(a)] = old;
    end
    req = 1; we = w; addr = a; wdata = d; mask = m;
    pend = 1; pend_we = w; pend_mask = m; pend_addr = a; req_smp = smp;
    n = 0;
    do begin
      @(negedge clk); #1; n++;
    end while (!ack && n < 300);
    chk(ack, {tag, " ack timeout"}, n, 0);
    if (!w && ack) chk(rdata == exp, tag, rdata, exp);
    req = 0;
  endtask

  initial begin
    #(CLK * 190000);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=0", 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK * 3 + 1);
    chk(ce_n && we_n && oe_n && be_n == 2'b11 && !dq_oe && !ack, "R1 reset state",
        {ce_n, we_n, oe_n, be_n, dq_oe, ack}, 7'b1111100);
    rst_n = 1;
    step(2);
    do_op(1, 17'h00000, 16'h1234, 2'b11, "R5 full write low addr");
    do_op(0, 17'h00000, 16'h0000, 2'b11, "R4 full read low addr");
    do_op(1, 17'h1FFFF, 16'hBEEF, 2'b11, "R5 full write top addr");
    do_op(0, 17'h1FFFF, 16'h0000, 2'b11, "R4 full read top addr");
    do_op(1, 17'h00000, 16'h55AA, 2'b01, "R3 lower lane write");
    do_op(0, 17'h00000, 16'h0000, 2'b11, "R3 read after lower write");
    do_op(1, 17'h1FFFF, 16'h7700, 2'b10, "R3 upper lane write");
    do_op(0, 17'h1FFFF, 16'h0000, 2'b11, "R3 read after upper write");
    do_op(1, 17'h00000, 16'hFFFF, 2'b00, "R8 masked write");
    do_op(0, 17'h00000, 16'h0000, 2'b11, "R8 memory unchanged");
    do_op(0, 17'h00000, 16'h0000, 2'b00, "R8 masked read zero");
    do_op(0, 17'h1FFFF, 16'h0000, 2'b01, "R4 lower lane read");
    do_op(0, 17'h1FFFF, 16'h0000, 2'b10, "R4 upper lane read");
    do_op(1, 17'h00010, 16'hC0DE, 2'b11, "R11 write right after read");
    step(3);
    do_op(0, 17'h00010, 16'h0000, 2'b11, "R4 read after idle");
    step(1);
    do_op(1, 17'h00011, 16'h0F0F, 2'b11, "R11 write one idle after read");
    for (int i = 0; i < 400; i++) begin
      bit w;
      logic [16:0] a;
      w = 1'($urandom_range(0, 1));
      a = (i % 3 == 0) ? 17'h1FFF0 + 17'($urandom_range(0, 15)) : 17'($urandom_range(0, 15));
      do_op(w, a, 16'($urandom), 2'($urandom_range(0, 3)), "R4 mixed traffic");
      step($urandom_range(0, 3));
    end
    step(4);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule